// File: doc/BRIEF.md
# Inter-Processor Interrupt Cause Unit

This block lets software running on any core raise software interrupts on any set of cores. Each core owns a 16-bit cause register. A single write to one of sixteen "raise" addresses sets one chosen cause bit in every core named by a core mask in the write data. A core acknowledges its causes by writing ones to its own cause address, which clears those bits.

Each core's cause bits are split into four groups, and each group is reduced to a single request. A shared steering register routes each group request to one of three interrupt lines per core, or drops it. The three lines of every core come out of registers, so they change one clock after the state that drives them.

Top module: `ipi_cause_unit`

## Requirements
- R1: A write to address 0x140+k (k = 0..15) sets cause bit k in every core c for which data bit c is 1; other cores and other bits are left unchanged.
- R2: The cause register of core c sits at address 0x100+c; a read returns the 16 cause bits in data bits 15:0 with the upper bits zero, and a write clears exactly the cause bits whose data bit is 1.
- R3: Cause bits are grouped as group 0 = bit 0, group 1 = bits 3:1, group 2 = bits 7:4, group 3 = bits 15:8; a group requests when any of its bits is 1.
- R4: The steering register at address 0x190 holds four 2-bit fields, bits 1:0, 3:2, 5:4 and 7:6 steering groups 0, 1, 2 and 3; it is written from data bits 7:0 and read back in data bits 7:0.
- R5: Group requests steered to the same line are ORed; a field value of 3 names no line, so that group reaches no output.
- R6: After reset every cause register, the steering register and every interrupt line are 0.
- R7: Line L (0..2) of core c is output bit 3c+L and is registered: it reflects the cause and steering state one clock after that state changes.
- R8: Mask bits for cores at or above NUM_CORES, clear writes to a core index at or above NUM_CORES, and writes to any unmapped address change no state; reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data (core mask, clear mask or steering fields) |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| ipiOut | output | NUM_CORES*3 | Interrupt lines, three per core |

## Verification
The steering register is swept through all 256 values, and for each one all sixteen combinations of active groups are built on one core, using a different bit inside each group per step so that the OR reduction is seen over its whole width; this separates a wrong field position, a wrong line index and a missing drop of value 3. Raise writes are swept over every cause index with every core mask, plus masks carrying bits of absent cores, which tells a per-core mask error from an index error. Clear writes with partial masks show that only the named bits fall and only in the addressed core, and one raise is observed edge by edge to pin the single register stage on the lines.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CAUSE_W    = 16;
  localparam int NUM_LINES  = 3;
  localparam int CAUSE_BASE = 'h100;
  localparam int SET_BASE   = 'h140;
  localparam int PART_ADDR  = 'h190;

  typedef struct packed {
    logic       setEn;
    logic [3:0] setIdx;
    logic       clrEn;
    logic [4:0] clrCore;
    logic       partEn;
  } wrStrobe_t;

  typedef enum logic [1:0] { RD_NONE, RD_CAUSE, RD_PART } rdKind_e;

  typedef struct packed {
    rdKind_e    kind;
    logic [4:0] core;
  } rdSel_t;

  // Reduce cause groups and steer them onto the three lines.
  function automatic logic [NUM_LINES-1:0] steerGroups(logic [CAUSE_W-1:0] cause,
                                                       logic [7:0] part);
    logic [3:0] grp;
    logic [NUM_LINES-1:0] lines;
    grp   = {|cause[15:8], |cause[7:4], |cause[3:1], cause[0]};
    lines = '0;
    for (int g = 0; g < 4; g++) begin
      case (part[2*g +: 2])
        2'd0:    lines[0] = lines[0] | grp[g];
        2'd1:    lines[1] = lines[1] | grp[g];
        2'd2:    lines[2] = lines[2] | grp[g];
        default: ;
      endcase
    end
    return lines;
  endfunction
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output wrStrobe_t         strobe,
  output rdSel_t            rdSel
);
  int wa;
  int ra;

  always_comb begin
    wa     = int'(wrAddr);
    strobe = '0;
    if (wrEn) begin
      if (wa >= SET_BASE && wa < SET_BASE + CAUSE_W) begin
        strobe.setEn  = 1'b1;
        strobe.setIdx = 4'(wa - SET_BASE);
      end else if (wa >= CAUSE_BASE && wa < CAUSE_BASE + NUM_CORES) begin
        strobe.clrEn   = 1'b1;
        strobe.clrCore = 5'(wa - CAUSE_BASE);
      end else if (wa == PART_ADDR) begin
        strobe.partEn = 1'b1;
      end
    end
  end

  always_comb begin
    ra    = int'(rdAddr);
    rdSel = '{kind: RD_NONE, core: 5'd0};
    if (ra >= CAUSE_BASE && ra < CAUSE_BASE + NUM_CORES) begin
      rdSel.kind = RD_CAUSE;
      rdSel.core = 5'(ra - CAUSE_BASE);
    end else if (ra == PART_ADDR) begin
      rdSel.kind = RD_PART;
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  wrStrobe_t                      strobe,
  input  logic [31:0]                    wrData,
  input  rdSel_t                         rdSel,
  output logic [31:0]                    rdData,
  output logic [NUM_CORES*CAUSE_W-1:0]   causeFlat,
  output logic [7:0]                     partReg,
  output logic [NUM_CORES*NUM_LINES-1:0] ipiOut
);
  logic [CAUSE_W-1:0] cause [NUM_CORES];
  logic [NUM_CORES*NUM_LINES-1:0] ipiNext;
  logic unusedDataBits;

  assign unusedDataBits = ^wrData;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CAUSE_W-1:0] setMask;
    logic [CAUSE_W-1:0] clrMask;

    always_comb begin
      setMask = '0;
      if (strobe.setEn && wrData[c]) setMask[strobe.setIdx] = 1'b1;
      clrMask = (strobe.clrEn && strobe.clrCore == 5'(c)) ? wrData[CAUSE_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cause[c] <= '0;
      else        cause[c] <= (cause[c] & ~clrMask) | setMask;
    end

    assign causeFlat[c*CAUSE_W +: CAUSE_W]     = cause[c];
    assign ipiNext[c*NUM_LINES +: NUM_LINES]   = steerGroups(cause[c], partReg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      partReg <= '0;
      ipiOut  <= '0;
    end else begin
      if (strobe.partEn) partReg <= wrData[7:0];
      ipiOut <= ipiNext;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel.kind)
      RD_CAUSE: rdData[CAUSE_W-1:0] = causeFlat[int'(rdSel.core)*CAUSE_W +: CAUSE_W];
      RD_PART:  rdData[7:0] = partReg;
      default:  ;
    endcase
  end
endmodule

// File: rtl/ipi_cause_unit.sv
module ipi_cause_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [31:0]                    wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [31:0]                    rdData,
  output logic [NUM_CORES*NUM_LINES-1:0] ipiOut
);
  wrStrobe_t strobe;
  rdSel_t    rdSel;
  logic [NUM_CORES*CAUSE_W-1:0] causeFlat;
  logic [7:0] partReg;

  ipi_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .strobe(strobe), .rdSel(rdSel)
  );

  ipi_datapath #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .causeFlat(causeFlat), .partReg(partReg), .ipiOut(ipiOut)
  );
endmodule

// File: rtl/ipi_cause_unit_checker.sv
module ipi_cause_unit_checker
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              wrAddr,
  input logic [31:0]                    wrData,
  input logic [NUM_CORES*CAUSE_W-1:0]   causeFlat,
  input logic [7:0]                     partReg,
  input logic [NUM_CORES*NUM_LINES-1:0] ipiOut
);
  logic isSet;
  logic isClr0;
  assign isSet  = wrEn && int'(wrAddr) >= SET_BASE && int'(wrAddr) < SET_BASE + CAUSE_W;
  assign isClr0 = wrEn && int'(wrAddr) == CAUSE_BASE;

  p_set_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (isSet && wrData[0]) |=> causeFlat[$past(wrAddr[3:0])]);

  p_set_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (isSet && !wrData[0]) |=> causeFlat[CAUSE_W-1:0] == $past(causeFlat[CAUSE_W-1:0]));

  p_clear_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    isClr0 |=> (causeFlat[CAUSE_W-1:0] & $past(wrData[CAUSE_W-1:0])) == '0);

  p_all_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (partReg == 8'hFF) |=> ipiOut == '0);

  p_registered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(causeFlat) && $stable(partReg)) |=> $stable(ipiOut));
endmodule

bind ipi_cause_unit ipi_cause_unit_checker #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .causeFlat(causeFlat), .partReg(partReg), .ipiOut(ipiOut)
);

// File: tb/ipi_cause_unit_test.sv
module ipi_cause_unit_test;
  localparam int NC = 4;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [NC*3-1:0] ipiOut;

  int checks = 0;
  int failures = 0;
  logic [15:0] mCause [NC];
  logic [7:0] mPart;

  always #10 clk = ~clk;

  ipi_cause_unit #(.NUM_CORES(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ipiOut(ipiOut)
  );

  function automatic logic [2:0] expLines(logic [15:0] c, logic [7:0] p);
    logic [2:0] r = '0;
    logic [3:0] g = {c[15:8] != 0, c[7:4] != 0, c[3:1] != 0, c[0]};
    for (int i = 0; i < 4; i++) begin
      int f = (p >> (2 * i)) & 3;
      if (f < 3 && g[i]) r[f] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NC*3-1:0] expAll();
    logic [NC*3-1:0] v;
    for (int c = 0; c < NC; c++) v[c*3 +: 3] = expLines(mCause[c], mPart);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rdAddr = AW'(a);
    #1 d = rdData;
  endtask

  task automatic checkAllCause(string req);
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      rd('h100 + c, d);
      check(req, d, {16'h0, mCause[c]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NC; c++) mCause[c] = '0;
    mPart = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: reset state
    check("R6 ipi", 32'(ipiOut), 0);
    checkAllCause("R6 cause");
    rd('h190, d); check("R6 part", d, 0);

    // R7: one register stage between a raise and the lines
    wr('h140, 32'h1); mCause[0][0] = 1'b1;
    check("R7 before", 32'(ipiOut), 0);
    @(negedge clk);
    check("R7 after", 32'(ipiOut), 32'(expAll()));
    wr('h100, 32'hFFFF); mCause[0] = '0;
    @(negedge clk);

    // R1: every index with every core mask (upper mask bits also set: R8)
    for (int k = 0; k < 16; k++) begin
      for (int m = 0; m < 16; m++) begin
        logic [31:0] msk = {28'hFFFFFFF, 4'(m)};
        wr('h140 + k, msk);
        for (int c = 0; c < NC; c++) if (msk[c]) mCause[c][k] = 1'b1;
        checkAllCause("R1 set");
        for (int c = 0; c < NC; c++) begin
          wr('h100 + c, 32'hFFFF); mCause[c] = '0;
        end
      end
    end

    // R2: partial write-1-to-clear touches only the addressed core
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 16; k++) begin
        wr('h140 + k, 32'hF);
        for (int j = 0; j < NC; j++) mCause[j][k] = 1'b1;
      end
    end
    for (int c = 0; c < NC; c++) begin
      logic [15:0] cm = 16'hA5C3 ^ 16'(c * 16'h1111);
      wr('h100 + c, {16'hFFFF, cm});
      mCause[c] = mCause[c] & ~cm;
      checkAllCause("R2 clear");
    end

    // R8: unmapped writes and absent-core clears change nothing
    wr('h100 + NC, 32'hFFFF);
    wr('h150, 32'hF);
    wr('h0FF, 32'hFFFF);
    wr('h191, 32'hFF);
    wr('h140, 32'hFFFFFFF0);
    checkAllCause("R8 ignored");
    rd('h190, d); check("R8 part kept", d, 32'(mPart));
    rd('h100 + NC, d); check("R8 read unmapped", d, 0);
    rd('h150, d); check("R8 read unmapped", d, 0);
    @(negedge clk);
    check("R8 ipi", 32'(ipiOut), 32'(expAll()));
    for (int c = 0; c < NC; c++) begin
      wr('h100 + c, 32'hFFFF); mCause[c] = '0;
    end

    // R3 R4 R5: all steering values against all group combinations on core 0
    for (int p = 0; p < 256; p++) begin
      wr('h190, 32'(p)); mPart = 8'(p);
      rd('h190, d); check("R4 readback", d, 32'(p));
      for (int g = 0; g < 16; g++) begin
        wr('h100, 32'hFFFF); mCause[0] = '0;
        if (g[0]) begin wr('h140, 32'h1); mCause[0][0] = 1'b1; end
        if (g[1]) begin
          int b = 1 + ((g + p) % 3);
          wr('h140 + b, 32'h1); mCause[0][b] = 1'b1;
        end
        if (g[2]) begin
          int b = 4 + ((g + p) % 4);
          wr('h140 + b, 32'h1); mCause[0][b] = 1'b1;
        end
        if (g[3]) begin
          int b = 8 + ((g + p) % 8);
          wr('h140 + b, 32'h1); mCause[0][b] = 1'b1;
        end
        @(negedge clk);
        check("R3 R5 lines", 32'(ipiOut), 32'(expAll()));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule